// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block performs the memory side of exception handling for a CPU with 32-bit addresses and a 16-bit big-endian data bus. When the core raises an exception, the block pushes a three-item frame onto the active stack: a 16-bit vector offset, the 32-bit return PC and the 16-bit status word. It then sets supervisor mode, clears tracing and reads the handler address from a vector table that can sit at any base address. A return request reverses this. It pops the status word and the PC, discards the frame's extra word, and hands back the restored values.

The core gives one request with a kind code and a 16-bit argument, together with its current PC, status register, vector base and stack pointer. The block answers with a one-cycle done pulse and the new PC, status word and stack pointer. Software traps, the conditional overflow trap and the stop request are decoded here as well. A stop loads the status word from the argument and parks the core. Every bus cycle waits for a ready handshake. A bus error stops the sequence, leaves the architectural values as they were and halts the core.

Top module: `exc_seq`

## Requirements
- R1: A request is taken only when `req_valid` is high, no sequence is in progress and `status` is running. In any other case it causes no `busy`, no `mem_req` and no `done`.
- R2: Exception entry performs four word writes in this order: (sp-2, vector number times 4), (sp-4, PC[15:0]), (sp-6, PC[31:16]) and (sp-8, old SR). On completion `sp_out` is sp-8.
- R3: After the writes, the new PC is read as two words, the high half from vbr+offset and the low half from vbr+offset+2, and is given on `pc_out`.
- R4: On entry, `sr_out` is the old SR with bit 13 (supervisor) set and bit 15 (trace) cleared. All other bits are kept.
- R5: `req_kind` encodes the request. 0 is an exception with vector `req_arg[7:0]`. 1 is a software trap with vector 32 + `req_arg[3:0]`. 2 is an overflow trap: vector 7 when SR bit 1 is set, otherwise it completes with no bus cycle and the outputs equal the inputs. 3 is a return. 4 is a stop. Codes 5 to 7 complete like an overflow trap that is not taken.
- R6: A return reads sp, sp+2, sp+4 and sp+6. `sr_out` is the first word, `pc_out` is the second word followed by the third, the fourth word is discarded, and `sp_out` is sp+8.
- R7: A stop makes no bus cycle. It sets `sr_out` to `req_arg` and moves `status` to stopped, where it stays until reset.
- R8: `mem_req` is held with unchanged `mem_addr`, `mem_we` and `mem_wdata` until `mem_ready` or `mem_err` is seen. Each sequence makes exactly the bus cycles given in R2, R3 and R6.
- R9: `mem_err` during any bus cycle ends the sequence. `done` and `err` are raised together, `pc_out`, `sr_out` and `sp_out` equal the values given with the request, and `status` becomes halted.
- R10: `status` encodes 0 init, 1 running, 2 stopped and 3 halted. After reset it is init, with `busy`, `done`, `err` and `mem_req` low and the three result outputs zero, and it becomes running one cycle later. `busy` is high from the accepting cycle until the cycle before `done`, and `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | Request kind code |
| req_arg | input | 16 | Vector number, trap number or stop immediate |
| pc_in | input | 32 | Current program counter |
| sr_in | input | 16 | Current status register |
| vbr_in | input | 32 | Vector table base address |
| sp_in | input | 32 | Active stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sequence aborted by a bus error, valid with done |
| pc_out | output | 32 | Resulting program counter |
| sr_out | output | 16 | Resulting status register |
| sp_out | output | 32 | Resulting stack pointer |
| status | output | 2 | Core state: init, running, stopped, halted |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Bus cycle completes |
| mem_err | input | 1 | Bus cycle failed |

## Verification
A wrong step counter or a wrong frame offset appears on the bus at once. The bus cycle that follows carries the wrong address, direction or data, so the logged beat sequence diverges on the first bad beat, before `done`. Faults in the captured handler or popped words, or in the status word edits, appear only on the result outputs in the `done` cycle. They are compared against values the bench takes from its own memory image. A status tracker that gets stuck or moves wrongly shows on `status` in the cycle after the event and in whether later requests are taken.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    K_VECTOR  = 3'd0,
    K_SWTRAP  = 3'd1,
    K_OVFTRAP = 3'd2,
    K_RETURN  = 3'd3,
    K_STOP    = 3'd4
  } req_kind_e;

  typedef enum logic [1:0] {
    ACT_ENTRY  = 2'd0,
    ACT_RETURN = 2'd1,
    ACT_STOP   = 2'd2,
    ACT_NONE   = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2,
    ST_HALT = 2'd3
  } core_st_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_BUS  = 1'b1
  } seq_e;
endpackage

// File: rtl/exc_req_decode.sv
module exc_req_decode
  import exc_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int TRAP_ARG_W = 4,
  parameter int TRAP_BASE  = 32,
  parameter int OVF_VEC    = 7
) (
  input  logic [2:0]       kind,
  input  logic [VEC_W-1:0] arg_vec,
  input  logic             ovf_flag,
  output act_e             act,
  output logic [VEC_W-1:0] vector
);
  always_comb begin
    act    = ACT_NONE;
    vector = '0;
    case (req_kind_e'(kind))
      K_VECTOR: begin
        act    = ACT_ENTRY;
        vector = arg_vec;
      end
      K_SWTRAP: begin
        act    = ACT_ENTRY;
        vector = VEC_W'(TRAP_BASE) + VEC_W'(arg_vec[TRAP_ARG_W-1:0]);
      end
      K_OVFTRAP: begin
        if (ovf_flag) begin
          act    = ACT_ENTRY;
          vector = VEC_W'(OVF_VEC);
        end
      end
      K_RETURN: act = ACT_RETURN;
      K_STOP:   act = ACT_STOP;
      default:  act = ACT_NONE;
    endcase
  end
endmodule

// File: rtl/exc_beat_gen.sv
module exc_beat_gen
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int STEP_W = 3
) (
  input  act_e                  act,
  input  logic [STEP_W-1:0]     step,
  input  logic [ADDR_W-1:0]     sp,
  input  logic [ADDR_W-1:0]     vbr,
  input  logic [ADDR_W-1:0]     off,
  input  logic [2*WORD_W-1:0]   pc,
  input  logic [WORD_W-1:0]     sr,
  output logic                  we,
  output logic [ADDR_W-1:0]     addr,
  output logic [WORD_W-1:0]     wdata,
  output logic                  last
);
  localparam int WB          = WORD_W / 8;
  localparam int WB_SH       = $clog2(WB);
  localparam int FRAME_WORDS = 4;
  localparam logic [ADDR_W-1:0] WBA = ADDR_W'(WB);

  always_comb begin
    we    = 1'b0;
    addr  = sp;
    wdata = sr;
    last  = 1'b0;
    if (act == ACT_ENTRY) begin
      case (step)
        STEP_W'(0): begin we = 1'b1; addr = sp - WBA;                 wdata = off[WORD_W-1:0]; end
        STEP_W'(1): begin we = 1'b1; addr = sp - (WBA << 1);          wdata = pc[WORD_W-1:0]; end
        STEP_W'(2): begin we = 1'b1; addr = sp - WBA - (WBA << 1);    wdata = pc[2*WORD_W-1:WORD_W]; end
        STEP_W'(3): begin we = 1'b1; addr = sp - (WBA << 2);          wdata = sr; end
        STEP_W'(4): addr = vbr + off;
        default: begin addr = vbr + off + WBA; last = 1'b1; end
      endcase
    end else begin
      addr = sp + (ADDR_W'(step) << WB_SH);
      last = (step == STEP_W'(FRAME_WORDS - 1));
    end
  end
endmodule

// File: rtl/exc_core_status.sv
module exc_core_status
  import exc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stop_evt,
  input  logic     halt_evt,
  output core_st_e st
);
  core_st_e st_d;

  always_comb begin
    st_d = st;
    case (st)
      ST_INIT: st_d = ST_RUN;
      ST_RUN: begin
        if (halt_evt)      st_d = ST_HALT;
        else if (stop_evt) st_d = ST_STOP;
      end
      default: st_d = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_INIT;
    else        st <= st_d;
  end

  p_init_leaves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_INIT |=> st == ST_RUN);
  p_stop_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_STOP |=> st == ST_STOP);
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_HALT |=> st == ST_HALT);
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 16,
  parameter int VEC_W      = 8,
  parameter int TRAP_ARG_W = 4,
  parameter int TRAP_BASE  = 32,
  parameter int OVF_VEC    = 7,
  parameter int OVF_BIT    = 1,
  parameter int SUP_BIT    = 13,
  parameter int TRC_BIT    = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          req_kind,
  input  logic [WORD_W-1:0]   req_arg,
  input  logic [2*WORD_W-1:0] pc_in,
  input  logic [WORD_W-1:0]   sr_in,
  input  logic [ADDR_W-1:0]   vbr_in,
  input  logic [ADDR_W-1:0]   sp_in,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [2*WORD_W-1:0] pc_out,
  output logic [WORD_W-1:0]   sr_out,
  output logic [ADDR_W-1:0]   sp_out,
  output logic [1:0]          status,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                mem_ready,
  input  logic                mem_err
);
  localparam int STEP_W   = 3;
  localparam int PC_W     = 2 * WORD_W;
  localparam int WB       = WORD_W / 8;
  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(4 * WB);
  localparam logic [WORD_W-1:0] SUP_MASK = WORD_W'(1) << SUP_BIT;
  localparam logic [WORD_W-1:0] TRC_MASK = WORD_W'(1) << TRC_BIT;

  core_st_e            core_st;
  seq_e                sq_q, sq_d;
  logic [STEP_W-1:0]   step_q, step_d;
  act_e                act_q, dec_act;
  logic [VEC_W-1:0]    dec_vec;
  logic [ADDR_W-1:0]   off_q, sp_c, vbr_c;
  logic [PC_W-1:0]     pc_c;
  logic [WORD_W-1:0]   sr_c;
  logic [WORD_W-1:0]   hi_q, lo_q, popsr_q;
  logic                accept, beat_ack, beat_last;
  logic                done_d, err_d, res_en, stop_evt, halt_evt;
  logic [PC_W-1:0]     res_pc;
  logic [WORD_W-1:0]   res_sr;
  logic [ADDR_W-1:0]   res_sp;

  exc_req_decode #(
    .VEC_W(VEC_W), .TRAP_ARG_W(TRAP_ARG_W), .TRAP_BASE(TRAP_BASE), .OVF_VEC(OVF_VEC)
  ) u_dec (
    .kind(req_kind), .arg_vec(req_arg[VEC_W-1:0]), .ovf_flag(sr_in[OVF_BIT]),
    .act(dec_act), .vector(dec_vec)
  );

  exc_beat_gen #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .STEP_W(STEP_W)) u_beat (
    .act(act_q), .step(step_q), .sp(sp_c), .vbr(vbr_c), .off(off_q),
    .pc(pc_c), .sr(sr_c), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
    .last(beat_last)
  );

  exc_core_status u_st (
    .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .halt_evt(halt_evt), .st(core_st)
  );

  assign status   = core_st;
  assign accept   = req_valid && (sq_q == SQ_IDLE) && (core_st == ST_RUN);
  assign mem_req  = (sq_q == SQ_BUS);
  assign beat_ack = mem_req && mem_ready && !mem_err;
  assign busy     = accept || (sq_q == SQ_BUS);

  // Next-state and result selection
  always_comb begin
    sq_d     = sq_q;
    step_d   = step_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    res_en   = 1'b0;
    res_pc   = pc_c;
    res_sr   = sr_c;
    res_sp   = sp_c;
    stop_evt = 1'b0;
    halt_evt = 1'b0;
    if (accept) begin
      case (dec_act)
        ACT_ENTRY, ACT_RETURN: begin
          sq_d   = SQ_BUS;
          step_d = '0;
        end
        ACT_STOP: begin
          done_d   = 1'b1;
          res_en   = 1'b1;
          res_pc   = pc_in;
          res_sr   = req_arg;
          res_sp   = sp_in;
          stop_evt = 1'b1;
        end
        default: begin
          done_d = 1'b1;
          res_en = 1'b1;
          res_pc = pc_in;
          res_sr = sr_in;
          res_sp = sp_in;
        end
      endcase
    end else if (sq_q == SQ_BUS) begin
      if (mem_err) begin
        sq_d     = SQ_IDLE;
        done_d   = 1'b1;
        err_d    = 1'b1;
        res_en   = 1'b1;
        halt_evt = 1'b1;
      end else if (mem_ready) begin
        if (beat_last) begin
          sq_d   = SQ_IDLE;
          done_d = 1'b1;
          res_en = 1'b1;
          if (act_q == ACT_ENTRY) begin
            res_pc = {hi_q, mem_rdata};
            res_sr = (sr_c | SUP_MASK) & ~TRC_MASK;
            res_sp = sp_c - FRAME_BYTES;
          end else begin
            res_pc = {hi_q, lo_q};
            res_sr = popsr_q;
            res_sp = sp_c + FRAME_BYTES;
          end
        end else begin
          step_d = step_q + STEP_W'(1);
        end
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= SQ_IDLE;
      step_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      sq_q   <= sq_d;
      step_q <= step_d;
      done   <= done_d;
      err    <= err_d;
    end
  end

  // Request capture, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= ACT_NONE;
      off_q <= '0;
      pc_c  <= '0;
      sr_c  <= '0;
      sp_c  <= '0;
      vbr_c <= '0;
    end else if (accept) begin
      act_q <= dec_act;
      off_q <= {{(ADDR_W-VEC_W-2){1'b0}}, dec_vec, 2'b00};
      pc_c  <= pc_in;
      sr_c  <= sr_in;
      sp_c  <= sp_in;
      vbr_c <= vbr_in;
    end
  end

  // Read-data capture, enabled on acknowledged beats
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      popsr_q <= '0;
    end else if (beat_ack) begin
      if (act_q == ACT_ENTRY) begin
        if (step_q == STEP_W'(4)) hi_q <= mem_rdata;
      end else begin
        if (step_q == STEP_W'(0)) popsr_q <= mem_rdata;
        if (step_q == STEP_W'(1)) hi_q    <= mem_rdata;
        if (step_q == STEP_W'(2)) lo_q    <= mem_rdata;
      end
    end
  end

  // Result registers, enabled at completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out <= '0;
      sr_out <= '0;
      sp_out <= '0;
    end else if (res_en) begin
      pc_out <= res_pc;
      sr_out <= res_sr;
      sp_out <= res_sp;
    end
  end

  p_quiet_unless_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    core_st != ST_RUN |-> !mem_req && !busy);
  p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready && !mem_err |=> mem_req && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_wdata));
  p_entry_sr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && act_q == ACT_ENTRY |-> sr_out[SUP_BIT] && !sr_out[TRC_BIT]);
  p_entry_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && act_q == ACT_ENTRY |-> sp_out == sp_c - FRAME_BYTES);
  p_err_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && core_st == ST_HALT);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/sim_exc_seq.sv
`timescale 1ns/1ps
module sim_exc_seq;
  logic        clk, rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [15:0] req_arg, sr_in;
  logic [31:0] pc_in, vbr_in, sp_in;
  logic        busy, done, err;
  logic [31:0] pc_out, sp_out;
  logic [15:0] sr_out;
  logic [1:0]  status;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_ready, mem_err;

  int checks = 0;
  int errors = 0;

  logic [15:0] mem [0:1023];
  int          beat_n;
  int          err_beat;
  logic        stall_en;
  logic [31:0] log_a [0:7];
  logic        log_w [0:7];
  logic [15:0] log_d [0:7];

  exc_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_arg(req_arg), .pc_in(pc_in), .sr_in(sr_in), .vbr_in(vbr_in), .sp_in(sp_in),
    .busy(busy), .done(done), .err(err), .pc_out(pc_out), .sr_out(sr_out),
    .sp_out(sp_out), .status(status), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .mem_err(mem_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ix(input logic [31:0] a);
    return int'(a[10:1]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder with random stalls and optional error injection
  initial begin
    mem_ready = 1'b0;
    mem_err   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      mem_err   = 1'b0;
      if (rst_n && mem_req && !(stall_en && ($urandom % 4 == 0))) begin
        mem_ready = 1'b1;
        mem_err   = (beat_n == err_beat);
        mem_rdata = mem[ix(mem_addr)];
        if (mem_we && !mem_err) mem[ix(mem_addr)] = mem_wdata;
        if (beat_n < 8) begin
          log_a[beat_n] = mem_addr;
          log_w[beat_n] = mem_we;
          log_d[beat_n] = mem_we ? mem_wdata : mem_rdata;
        end
        beat_n++;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_op(input string tag, input logic [2:0] kind, input logic [15:0] arg,
                        input logic [31:0] pc, input logic [15:0] sr,
                        input logic [31:0] vbr, input logic [31:0] sp,
                        input int err_at, input int hold);
    logic [31:0] ea [0:5];
    logic        ew [0:5];
    logic [15:0] ed [0:5];
    int          nb, vec, cyc;
    logic [31:0] off, epc, esp;
    logic [15:0] esr;
    logic        entry;
    vec = -1;
    if (kind == 3'd0) vec = int'(arg[7:0]);
    if (kind == 3'd1) vec = 32 + int'(arg[3:0]);
    if (kind == 3'd2 && sr[1]) vec = 7;
    entry = (vec >= 0);
    off = 32'(vec) << 2;
    nb = 0; epc = pc; esr = sr; esp = sp;
    if (entry) begin
      ea[0] = sp - 2; ew[0] = 1; ed[0] = off[15:0];
      ea[1] = sp - 4; ew[1] = 1; ed[1] = pc[15:0];
      ea[2] = sp - 6; ew[2] = 1; ed[2] = pc[31:16];
      ea[3] = sp - 8; ew[3] = 1; ed[3] = sr;
      ea[4] = vbr + off; ew[4] = 0; ed[4] = '0;
      ea[5] = vbr + off + 2; ew[5] = 0; ed[5] = '0;
      nb = 6;
      epc = {mem[ix(vbr + off)], mem[ix(vbr + off + 2)]};
      esr = (sr | 16'h2000) & 16'h7FFF;
      esp = sp - 8;
    end else if (kind == 3'd3) begin
      for (int i = 0; i < 4; i++) begin
        ea[i] = sp + 32'(2 * i); ew[i] = 0; ed[i] = '0;
      end
      nb = 4;
      esr = mem[ix(sp)];
      epc = {mem[ix(sp + 2)], mem[ix(sp + 4)]};
      esp = sp + 8;
    end else if (kind == 3'd4) begin
      esr = arg;
    end
    if (err_at >= 0) begin
      nb = err_at + 1; epc = pc; esr = sr; esp = sp;
    end
    beat_n = 0;
    err_beat = err_at;
    @(negedge clk);
    req_kind = kind; req_arg = arg; pc_in = pc; sr_in = sr; vbr_in = vbr; sp_in = sp;
    req_valid = 1'b1;
    #1;
    chk({tag, " R10 busy on accept"}, 32'(busy), 32'd1);
    for (int h = 0; h < hold; h++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " R10 done seen"}, 32'(done), 32'd1);
    chk({tag, " R9 err flag"}, 32'(err), (err_at >= 0) ? 32'd1 : 32'd0);
    chk({tag, " pc_out"}, pc_out, epc);
    chk({tag, " sr_out"}, 32'(sr_out), 32'(esr));
    chk({tag, " sp_out"}, sp_out, esp);
    chk({tag, " status"}, 32'(status),
        (err_at >= 0) ? 32'd3 : ((kind == 3'd4) ? 32'd2 : 32'd1));
    chk({tag, " R8 beat count"}, 32'(beat_n), 32'(nb));
    for (int i = 0; i < nb && i < 6; i++) begin
      chk({tag, " R8 beat addr"}, log_a[i], ea[i]);
      chk({tag, " R8 beat dir"}, 32'(log_w[i]), 32'(ew[i]));
      if (ew[i] && i != err_at) chk({tag, " R2 write data"}, 32'(log_d[i]), 32'(ed[i]));
    end
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, 32'(done), 32'd0);
    chk({tag, " R8 bus idle after"}, 32'(mem_req), 32'd0);
    err_beat = -1;
  endtask

  task automatic expect_ignored(input string tag);
    int seen;
    seen = 0;
    @(negedge clk);
    req_kind = 3'd0; req_arg = 16'h0040; req_valid = 1'b1;
    #1;
    seen = seen | int'(busy);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      seen = seen | int'(busy) | int'(mem_req) | int'(done);
    end
    req_valid = 1'b0;
    chk({tag, " R1 request ignored"}, 32'(seen), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 16'($urandom);
    beat_n = 0; err_beat = -1; stall_en = 1'b0;
    req_kind = '0; req_arg = '0; pc_in = '0; sr_in = '0; vbr_in = '0; sp_in = '0;
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 reset status", 32'(status), 32'd0);
    chk("R10 reset busy/done/err/req", {28'd0, busy, done, err, mem_req}, 32'd0);
    chk("R10 reset outputs", pc_out | sp_out | 32'(sr_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 running after init", 32'(status), 32'd1);

    run_op("R2 R3 R4 vector 0x19", 3'd0, 16'h0019, 32'h1234_5678, 16'h8005,
           32'h0000_0020, 32'h0000_0600, -1, 0);
    run_op("R3 vector 255", 3'd0, 16'hFFFF, 32'hCAFE_0002, 16'h2700,
           32'h0000_003C, 32'h0000_06F0, -1, 0);
    run_op("R5 swtrap 15", 3'd1, 16'h00FF, 32'hA0B0_C0D0, 16'h0000,
           32'h0000_0000, 32'h0000_0580, -1, 0);
    run_op("R5 ovf trap clear", 3'd2, 16'h0000, 32'h0000_1000, 16'h0001,
           32'h0, 32'h0000_0600, -1, 0);
    run_op("R5 ovf trap set", 3'd2, 16'h0000, 32'h0000_1000, 16'h0002,
           32'h0, 32'h0000_0600, -1, 0);
    run_op("R6 return", 3'd3, 16'h0000, 32'h0, 16'h2000,
           32'h0, 32'h0000_05F8, -1, 0);
    run_op("R5 unknown kind", 3'd6, 16'h1111, 32'h5555_AAAA, 16'h1234,
           32'h0, 32'h0000_0600, -1, 0);
    run_op("R1 held request", 3'd0, 16'h0003, 32'h0BAD_F00D, 16'h0000,
           32'h4, 32'h0000_0640, -1, 3);

    stall_en = 1'b1;
    for (int n = 0; n < 40; n++) begin
      run_op("rand", 3'($urandom % 4), 16'($urandom), $urandom, 16'($urandom),
             32'(4 * ($urandom % 16)), 32'h500 + 32'(2 * ($urandom % 256)), -1, 0);
    end

    run_op("R7 stop", 3'd4, 16'h2704, 32'h0000_2000, 16'h0000,
           32'h0, 32'h0000_0600, -1, 0);
    expect_ignored("R7 stopped");
    do_reset();
    @(negedge clk);
    run_op("R9 error entry", 3'd0, 16'h0010, 32'h7777_8888, 16'h0700,
           32'h0, 32'h0000_0600, 2, 0);
    expect_ignored("R9 halted");
    do_reset();
    @(negedge clk);
    run_op("R9 error return", 3'd3, 16'h0000, 32'h1, 16'h0002,
           32'h0, 32'h0000_0600, 0, 0);
    do_reset();
    @(negedge clk);
    run_op("R6 return after reset", 3'd3, 16'h0000, 32'h0, 16'h0000,
           32'h0, 32'h0000_0610, -1, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule